// File: doc/BRIEF.md
# Pattern-Matched Event Counter Unit

This unit watches a word of debug bits that a crossbar delivers, split into fixed-width lanes. Each lane comes with a toggle line from its own native clock. A set of event detectors compares the sampled word with a programmable mask and match pair. A bank of counters, each bound to one selected event, counts either the event's rising edges or the cycles in which the event is true. A counter counts up or down, saturates at its limits and starts from a preloaded value. If a lane's native clock stops, every event that looks at that lane is forced false, so a frozen input is not counted.

Software programs the unit through a word-wide register port and reads counter values through the same port. A snapshot request copies all counters at once. A small state machine then emits them as a burst of trace records, one counter per cycle. The machine has three states. From `TR_IDLE` it goes to `TR_LATCH` on a snapshot request. From `TR_LATCH` it always goes to `TR_EMIT`, and in that step it copies the counters. In `TR_EMIT` it stays while the record index is below the last counter, and it returns to `TR_IDLE` after emitting the last record.

Top module: `evtcnt_unit`

## Requirements
- R1: Event e is true when `((sample ^ match_e) & mask_e) == 0`, so an all-zero mask makes the event always true. Register word address `4*e` holds mask_e and `4*e+1` holds match_e.
- R2: With config bit 5 clear (occurrence mode), an enabled counter steps once on each cycle where its event is true and was false in the previous cycle. After reset the previous value counts as false.
- R3: With config bit 5 set (duration mode), an enabled counter steps on every cycle where its event is true.
- R4: Config bit 4 selects the direction: clear means +1 and set means -1. A counter changes by at most one per cycle unless a load happens.
- R5: An incrementing counter holds at all-ones and a decrementing counter holds at zero.
- R6: A step attempted at the limit sets the counter's sticky flag (bit 0 at address `0x40+4*c+3`). Writing 1 to that bit clears the flag. A saturation in the same cycle wins over the clear.
- R7: Writing counter c's config (address `0x40+4*c`) with bit 7 set loads the preload value (address `0x40+4*c+1`) into the counter on the following cycle. The load replaces any count step in that cycle.
- R8: A counter whose enable (config bit 6) is clear holds its value. Config bits 3:0 select the event, and an index beyond the last event never fires.
- R9: A lane whose toggle input has not changed for OFF_LIMIT consecutive cycles is clock-off. Any event with a mask bit in that lane is then false. Events that use other lanes are unaffected. One toggle makes the lane live again from the next cycle.
- R10: A read strobe returns the addressed register on `reg_rdata_o` after the next clock edge, and the output holds between reads. The count value register (address `0x40+4*c+2`) ignores writes.
- R11: Writing 1 to bit 0 at address `0x80` while idle captures all counters one cycle later. Records with ids 0 to NUM_CNT-1 are then emitted on consecutive cycles. A request made while a snapshot is in progress is ignored.
- R12: After reset, counters, flags and read data are zero and no trace record is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | NUM_LANES*LANE_W | Sampled debug bits, lane l in bits l*LANE_W upward |
| lane_tog_i | input | NUM_LANES | Per-lane toggle derived from each native clock |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Word address {page[1:0], index[3:0], sub[1:0]} |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid after the edge that took the read |
| trace_valid_o | output | 1 | Trace record valid |
| trace_id_o | output | 4 | Counter index of the record |
| trace_data_o | output | CNT_W | Captured counter value |

## Verification
The embedded properties check, on every cycle, that a counter moves by at most one step, holds at its limits, holds when disabled, and takes the preload after a load. They also check that the sticky flag stays set until cleared, that lane status follows the toggle rules, that trace ids run in sequence and that the read data holds between reads. Only the bench scenarios can show that the mask and match logic picks the right events, that occurrence and duration modes give the right totals over random traffic, and that a stopped lane suppresses exactly the events that depend on it. Those scenarios also show that a snapshot request made during a burst is dropped.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // address pages and sub-addresses
    localparam logic [1:0] PAGE_EVT  = 2'd0;
    localparam logic [1:0] PAGE_CNT  = 2'd1;
    localparam logic [1:0] PAGE_TRC  = 2'd2;
    localparam logic [1:0] SUB_MASK  = 2'd0;
    localparam logic [1:0] SUB_MATCH = 2'd1;
    localparam logic [1:0] SUB_CFG   = 2'd0;
    localparam logic [1:0] SUB_PRE   = 2'd1;
    localparam logic [1:0] SUB_VAL   = 2'd2;
    localparam logic [1:0] SUB_FLAG  = 2'd3;
    localparam int CFG_LOAD_BIT      = 7;
    localparam int CFG_W             = 7;

    typedef struct packed {
        logic       en;     // bit 6
        logic       dur;    // bit 5
        logic       down;   // bit 4
        logic [3:0] evsel;  // bits 3:0
    } cnt_cfg_t;

    typedef enum logic [1:0] {
        TR_IDLE  = 2'd0,
        TR_LATCH = 2'd1,
        TR_EMIT  = 2'd2
    } trace_state_e;
endpackage

// File: rtl/evtcnt_lane_watch.sv
module evtcnt_lane_watch #(
    parameter int OFF_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_i,
    output logic off_o
);
    localparam int IW = $clog2(OFF_LIMIT + 1);
    localparam logic [IW-1:0] LIMIT = IW'(OFF_LIMIT);

    logic          tog_q;
    logic [IW-1:0] idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q  <= 1'b0;
            idle_q <= '0;
        end else begin
            tog_q <= tog_i;
            if (tog_i != tog_q)
                idle_q <= '0;
            else if (idle_q != LIMIT)
                idle_q <= idle_q + 1'b1;
        end
    end

    assign off_o = (idle_q == LIMIT);

    assert_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (off_o && (tog_i == tog_q)) |=> off_o);
    assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_i != tog_q) |=> !off_o);
endmodule

// File: rtl/evtcnt_matcher.sv
module evtcnt_matcher #(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 8
) (
    input  logic [NUM_LANES*LANE_W-1:0] sample_i,
    input  logic [NUM_LANES*LANE_W-1:0] mask_i,
    input  logic [NUM_LANES*LANE_W-1:0] match_i,
    input  logic [NUM_LANES-1:0]        lane_off_i,
    output logic                        hit_o
);
    logic [NUM_LANES-1:0] lane_used;
    logic                 blocked;
    logic                 pattern_ok;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_use
        assign lane_used[g] = |mask_i[g*LANE_W +: LANE_W];
    end

    assign blocked    = |(lane_used & lane_off_i);
    assign pattern_ok = (((sample_i ^ match_i) & mask_i) == '0);
    assign hit_o      = pattern_ok && !blocked;
endmodule

// File: rtl/evtcnt_counter.sv
module evtcnt_counter
    import evtcnt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cnt_cfg_t           cfg_i,
    input  logic [CNT_W-1:0]   preload_i,
    input  logic               load_i,
    input  logic               flag_clr_i,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] evt_prev_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               flag_o
);
    localparam logic [4:0] EVT_LIM = 5'(NUM_EVT);

    logic [15:0]      evt_pad;
    logic [15:0]      prev_pad;
    logic             ev_now;
    logic             ev_before;
    logic             step;
    logic             at_limit;
    logic             sat_hit;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;

    assign evt_pad  = 16'(evt_i);
    assign prev_pad = 16'(evt_prev_i);

    always_comb begin
        if ({1'b0, cfg_i.evsel} < EVT_LIM) begin
            ev_now    = evt_pad[cfg_i.evsel];
            ev_before = prev_pad[cfg_i.evsel];
        end else begin
            ev_now    = 1'b0;
            ev_before = 1'b0;
        end
        step     = cfg_i.dur ? ev_now : (ev_now && !ev_before);
        at_limit = cfg_i.down ? (cnt_q == '0) : (cnt_q == '1);
        sat_hit  = !load_i && cfg_i.en && step && at_limit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= preload_i;
        end else if (cfg_i.en && step && !at_limit) begin
            if (cfg_i.down)
                cnt_q <= cnt_q - 1'b1;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (sat_hit)
            flag_q <= 1'b1;
        else if (flag_clr_i)
            flag_q <= 1'b0;
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;

    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(preload_i)));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !cfg_i.en) |=> $stable(cnt_q));
    assert_sat_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !cfg_i.down && (cnt_q == '1)) |=> (cnt_q == '1));
    assert_sat_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cfg_i.down && (cnt_q == '0)) |=> (cnt_q == '0));
    assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ((cnt_q == $past(cnt_q)) ||
                     (cnt_q == $past(cnt_q) + CNT_W'(1)) ||
                     (cnt_q == $past(cnt_q) - CNT_W'(1))));
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr_i) |=> flag_q);
endmodule

// File: rtl/evtcnt_trace_fsm.sv
module evtcnt_trace_fsm
    import evtcnt_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_i,
    input  logic [NUM_CNT*CNT_W-1:0] cnt_flat_i,
    output logic                     valid_o,
    output logic [3:0]               id_o,
    output logic [CNT_W-1:0]         data_o
);
    localparam int IDXW = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
    localparam logic [IDXW-1:0] LAST = IDXW'(NUM_CNT - 1);

    trace_state_e    state_q, state_d;
    logic [IDXW-1:0] idx_q;
    logic [CNT_W-1:0] snap_q [NUM_CNT];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TR_IDLE:  if (req_i) state_d = TR_LATCH;
            TR_LATCH: state_d = TR_EMIT;
            TR_EMIT:  if (idx_q == LAST) state_d = TR_IDLE;
            default:  state_d = TR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TR_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int c = 0; c < NUM_CNT; c++) snap_q[c] <= '0;
        end else if (state_q == TR_LATCH) begin
            idx_q <= '0;
            for (int c = 0; c < NUM_CNT; c++) snap_q[c] <= cnt_flat_i[c*CNT_W +: CNT_W];
        end else if (state_q == TR_EMIT) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        valid_o = 1'b0;
        id_o    = '0;
        data_o  = '0;
        unique case (state_q)
            TR_EMIT: begin
                valid_o = 1'b1;
                id_o    = 4'(idx_q);
                data_o  = snap_q[idx_q];
            end
            default: ;
        endcase
    end

    assert_first_id_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (id_o == 4'd0));
    assert_id_seq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (id_o != 4'(LAST))) |=> (valid_o && (id_o == $past(id_o) + 4'd1)));
    assert_burst_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (id_o == 4'(LAST))) |=> !valid_o);
endmodule

// File: rtl/evtcnt_unit.sv
module evtcnt_unit
    import evtcnt_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 8,
    parameter int NUM_EVT   = 4,
    parameter int NUM_CNT   = 4,
    parameter int CNT_W     = 32,
    parameter int OFF_LIMIT = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LANES*LANE_W-1:0] sample_i,
    input  logic [NUM_LANES-1:0]        lane_tog_i,
    input  logic                        reg_we_i,
    input  logic                        reg_re_i,
    input  logic [7:0]                  reg_addr_i,
    input  logic [31:0]                 reg_wdata_i,
    output logic [31:0]                 reg_rdata_o,
    output logic                        trace_valid_o,
    output logic [3:0]                  trace_id_o,
    output logic [CNT_W-1:0]            trace_data_o
);
    localparam int SAMPLE_W = NUM_LANES * LANE_W;

    logic [1:0] a_page;
    logic [3:0] a_idx;
    logic [1:0] a_sub;
    assign {a_page, a_idx, a_sub} = reg_addr_i;

    logic [SAMPLE_W-1:0]      mask_q  [NUM_EVT];
    logic [SAMPLE_W-1:0]      match_q [NUM_EVT];
    cnt_cfg_t                 cfg_q   [NUM_CNT];
    logic [CNT_W-1:0]         pre_q   [NUM_CNT];
    logic [NUM_CNT-1:0]       load_q;
    logic [NUM_CNT-1:0]       flag_clr;
    logic [NUM_CNT-1:0]       flag;
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;
    logic [NUM_LANES-1:0]     lane_off;
    logic [NUM_EVT-1:0]       evt_now;
    logic [NUM_EVT-1:0]       evt_prev_q;
    logic                     trace_req;
    logic [DATA_W-1:0]        rd_val;
    logic [DATA_W-1:0]        rdata_q;

    // lane clock watchers
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        evtcnt_lane_watch #(.OFF_LIMIT(OFF_LIMIT)) u_watch (
            .clk   (clk),
            .rst_n (rst_n),
            .tog_i (lane_tog_i[g]),
            .off_o (lane_off[g])
        );
    end

    // event detectors
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        evtcnt_matcher #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_match (
            .sample_i   (sample_i),
            .mask_i     (mask_q[g]),
            .match_i    (match_q[g]),
            .lane_off_i (lane_off),
            .hit_o      (evt_now[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_prev_q <= '0;
        else        evt_prev_q <= evt_now;
    end

    // counters
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        assign flag_clr[g] = reg_we_i && (a_page == PAGE_CNT) && (a_idx == 4'(g)) &&
                             (a_sub == SUB_FLAG) && reg_wdata_i[0];
        evtcnt_counter #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_i      (cfg_q[g]),
            .preload_i  (pre_q[g]),
            .load_i     (load_q[g]),
            .flag_clr_i (flag_clr[g]),
            .evt_i      (evt_now),
            .evt_prev_i (evt_prev_q),
            .cnt_o      (cnt_flat[g*CNT_W +: CNT_W]),
            .flag_o     (flag[g])
        );
    end

    // event register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_EVT; e++) begin
                mask_q[e]  <= '0;
                match_q[e] <= '0;
            end
        end else if (reg_we_i && (a_page == PAGE_EVT)) begin
            for (int e = 0; e < NUM_EVT; e++) begin
                if (a_idx == 4'(e)) begin
                    if (a_sub == SUB_MASK)  mask_q[e]  <= reg_wdata_i[SAMPLE_W-1:0];
                    if (a_sub == SUB_MATCH) match_q[e] <= reg_wdata_i[SAMPLE_W-1:0];
                end
            end
        end
    end

    // counter register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
            for (int c = 0; c < NUM_CNT; c++) begin
                cfg_q[c] <= '0;
                pre_q[c] <= '0;
            end
        end else begin
            load_q <= '0;
            if (reg_we_i && (a_page == PAGE_CNT)) begin
                for (int c = 0; c < NUM_CNT; c++) begin
                    if (a_idx == 4'(c)) begin
                        if (a_sub == SUB_CFG) begin
                            cfg_q[c]  <= cnt_cfg_t'(reg_wdata_i[CFG_W-1:0]);
                            load_q[c] <= reg_wdata_i[CFG_LOAD_BIT];
                        end
                        if (a_sub == SUB_PRE) pre_q[c] <= reg_wdata_i[CNT_W-1:0];
                    end
                end
            end
        end
    end

    // snapshot trace
    assign trace_req = reg_we_i && (a_page == PAGE_TRC) && (a_idx == 4'd0) &&
                       (a_sub == 2'd0) && reg_wdata_i[0];

    evtcnt_trace_fsm #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_trace (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (trace_req),
        .cnt_flat_i (cnt_flat),
        .valid_o    (trace_valid_o),
        .id_o       (trace_id_o),
        .data_o     (trace_data_o)
    );

    // read path
    always_comb begin
        rd_val = '0;
        if (a_page == PAGE_EVT) begin
            for (int e = 0; e < NUM_EVT; e++) begin
                if (a_idx == 4'(e)) begin
                    if (a_sub == SUB_MASK)  rd_val = DATA_W'(mask_q[e]);
                    if (a_sub == SUB_MATCH) rd_val = DATA_W'(match_q[e]);
                end
            end
        end else if (a_page == PAGE_CNT) begin
            for (int c = 0; c < NUM_CNT; c++) begin
                if (a_idx == 4'(c)) begin
                    unique case (a_sub)
                        SUB_CFG:  rd_val = DATA_W'(cfg_q[c]);
                        SUB_PRE:  rd_val = DATA_W'(pre_q[c]);
                        SUB_VAL:  rd_val = DATA_W'(cnt_flat[c*CNT_W +: CNT_W]);
                        SUB_FLAG: rd_val = DATA_W'(flag[c]);
                        default:  rd_val = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata_q <= '0;
        else if (reg_re_i) rdata_q <= rd_val;
    end

    assign reg_rdata_o = rdata_q;

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re_i |=> $stable(reg_rdata_o));
endmodule

// File: tb/evtcnt_unit_bench.sv
module evtcnt_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL  = 4;
    localparam int LW  = 8;
    localparam int NE  = 4;
    localparam int NC  = 4;
    localparam int OFF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sample = '0;
    logic [NL-1:0] lane_tog = '0;
    logic [NL-1:0] live = '1;
    logic        we = 1'b0, re = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tvalid;
    logic [3:0]  tid;
    logic [31:0] tdata;

    int n_chk = 0, n_fail = 0, n_rec = 0;
    logic [3:0]  rec_id   [16];
    logic [31:0] rec_data [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    evtcnt_unit u_evtcnt_unit (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .lane_tog_i(lane_tog),
        .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .trace_valid_o(tvalid), .trace_id_o(tid), .trace_data_o(tdata)
    );

    always @(negedge clk) lane_tog = lane_tog ^ live;

    always @(negedge clk) begin
        if (tvalid && n_rec < 16) begin
            rec_id[n_rec]   = tid;
            rec_data[n_rec] = tdata;
            n_rec++;
        end
    end

    // reference model built from the requirements
    logic [31:0] m_mask [NE], m_match [NE], m_pre [NC], m_cnt [NC];
    logic [6:0]  m_cfg [NC];
    logic        m_load [NC], m_flag [NC];
    logic        m_prev [16];
    int          m_idle [NL];
    logic        m_togq [NL];

    function automatic logic f_hit(input logic [31:0] mask, input logic [31:0] match,
                                   input logic [31:0] smp, input logic [NL-1:0] off);
        for (int l = 0; l < NL; l++)
            if ((|mask[l*LW +: LW]) && off[l]) return 1'b0;
        return (((smp ^ match) & mask) == 32'd0);
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        logic [NL-1:0] offv;
        logic evv [16];
        logic [3:0] sel;
        logic ev, pv, step, lim, sat;
        logic [1:0] pg, sb;
        logic [3:0] ix;
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) begin m_mask[i] = 0; m_match[i] = 0; end
            for (int i = 0; i < 16; i++) m_prev[i] = 0;
            for (int i = 0; i < NC; i++) begin
                m_pre[i] = 0; m_cnt[i] = 0; m_cfg[i] = 0; m_load[i] = 0; m_flag[i] = 0;
            end
            for (int l = 0; l < NL; l++) begin m_idle[l] = 0; m_togq[l] = 0; end
        end else begin
            {pg, ix, sb} = addr;
            for (int l = 0; l < NL; l++) offv[l] = (m_idle[l] == OFF);
            for (int i = 0; i < 16; i++) evv[i] = 1'b0;
            for (int e = 0; e < NE; e++) evv[e] = f_hit(m_mask[e], m_match[e], sample, offv);
            for (int c = 0; c < NC; c++) begin
                sel  = m_cfg[c][3:0];
                ev   = evv[sel];
                pv   = m_prev[sel];
                step = m_cfg[c][5] ? ev : (ev && !pv);
                lim  = m_cfg[c][4] ? (m_cnt[c] == 32'd0) : (m_cnt[c] == 32'hFFFF_FFFF);
                sat  = 1'b0;
                if (m_load[c]) m_cnt[c] = m_pre[c];
                else if (m_cfg[c][6] && step) begin
                    if (lim) sat = 1'b1;
                    else if (m_cfg[c][4]) m_cnt[c] = m_cnt[c] - 1;
                    else m_cnt[c] = m_cnt[c] + 1;
                end
                if (sat) m_flag[c] = 1'b1;
                else if (we && pg == 2'd1 && ix == 4'(c) && sb == 2'd3 && wdata[0]) m_flag[c] = 1'b0;
            end
            for (int e = 0; e < 16; e++) m_prev[e] = evv[e];
            for (int l = 0; l < NL; l++) begin
                if (lane_tog[l] != m_togq[l]) m_idle[l] = 0;
                else if (m_idle[l] != OFF) m_idle[l] = m_idle[l] + 1;
                m_togq[l] = lane_tog[l];
            end
            for (int c = 0; c < NC; c++) m_load[c] = 1'b0;
            if (we && pg == 2'd0 && ix < NE) begin
                if (sb == 2'd0) m_mask[ix]  = wdata;
                if (sb == 2'd1) m_match[ix] = wdata;
            end
            if (we && pg == 2'd1 && ix < NC) begin
                if (sb == 2'd0) begin m_cfg[ix] = wdata[6:0]; m_load[ix] = wdata[7]; end
                if (sb == 2'd1) m_pre[ix] = wdata;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        re = 1'b1; addr = a;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v, v2;
        logic [6:0]  cfg;
        logic [31:0] pats [9];
        int r;
        pats = '{32'h5A, 32'h5A, 32'h0, 32'h5A, 32'h0, 32'h0, 32'h5A, 32'h5A, 32'h5A};
        r = $urandom(32'd31337);
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R12 reset state
        check("R12 rdata after reset", rdata, 32'd0);
        check("R12 trace idle", {31'd0, tvalid}, 32'd0);
        rd(8'h42, v); check("R12 count zero", v, 32'd0);
        rd(8'h43, v); check("R12 flag zero", v, 32'd0);

        // R7 R5 R6: load priority, upward saturation, sticky flag
        wr(8'h41, 32'hFFFF_FFFD);
        wr(8'h40, 32'hE0);
        idle(1);
        rd(8'h42, v); check("R7 load wins over step", v, 32'hFFFF_FFFD);
        idle(4);
        wr(8'h40, 32'h20);
        rd(8'h42, v); check("R5 hold at all-ones", v, 32'hFFFF_FFFF);
        rd(8'h43, v); check("R6 flag set on saturation", v, 32'd1);
        wr(8'h43, 32'd1);
        rd(8'h43, v); check("R6 flag cleared", v, 32'd0);
        wr(8'h42, 32'h1234);
        rd(8'h42, v); check("R10 value register ignores write", v, 32'hFFFF_FFFF);

        // R4 R5 downward
        wr(8'h41, 32'd2);
        wr(8'h40, 32'hF0);
        idle(5);
        wr(8'h40, 32'h30);
        rd(8'h42, v); check("R4 R5 count down to zero and hold", v, 32'd0);
        rd(8'h43, v); check("R6 flag set at zero", v, 32'd1);
        wr(8'h43, 32'd1);

        // R1 R2 R3 occurrence vs duration on a byte pattern
        wr(8'h04, 32'hFF);
        wr(8'h05, 32'h5A);
        wr(8'h44, 32'hC1);
        wr(8'h48, 32'hE1);
        idle(1);
        for (int i = 0; i < 9; i++) begin sample = pats[i]; @(negedge clk); end
        sample = '0;
        wr(8'h44, 32'h01);
        wr(8'h48, 32'h21);
        rd(8'h46, v); check("R2 occurrence count", v, 32'd3);
        rd(8'h4A, v); check("R1 R3 duration count", v, 32'd6);
        rd(8'h05, v); check("R1 match register readback", v, 32'h5A);

        // R9 lane clock-off
        wr(8'h08, 32'h0000_FF00); wr(8'h09, 32'h0000_3300);
        wr(8'h0C, 32'h0000_00FF); wr(8'h0D, 32'h0000_0011);
        wr(8'h41, 32'd0); wr(8'h4D, 32'd0);
        sample = 32'h0000_3311;
        live = 4'b1101;
        idle(6);
        wr(8'h40, 32'hE2);
        wr(8'h4C, 32'hE3);
        idle(8);
        wr(8'h40, 32'h22);
        wr(8'h4C, 32'h23);
        rd(8'h42, v); check("R9 stopped lane blocks event", v, 32'd0);
        rd(8'h4E, v); check("R9 other lane keeps counting", v, m_cnt[3]);
        check("R9 other lane count nonzero", {31'd0, v != 0}, 32'd1);
        live = '1;
        idle(3);
        wr(8'h40, 32'h62);
        idle(5);
        wr(8'h40, 32'h22);
        rd(8'h42, v); check("R9 lane recovers", v, m_cnt[0]);
        check("R9 recovered count nonzero", {31'd0, v != 0}, 32'd1);
        sample = '0;

        // R11 snapshot burst, second request ignored
        n_rec = 0;
        wr(8'h80, 32'd1);
        wr(8'h80, 32'd1);
        idle(10);
        check("R11 one burst of records", n_rec, NC);
        for (int c = 0; c < NC; c++) begin
            check("R11 record id", {28'd0, rec_id[c]}, c);
            check("R11 record data", rec_data[c], m_cnt[c]);
        end
        wr(8'h80, 32'd1);
        idle(8);
        check("R11 later request served", n_rec, 2 * NC);

        // R8 disabled counter holds under traffic
        rd(8'h46, v);
        for (int i = 0; i < 6; i++) begin sample = pats[i]; @(negedge clk); end
        sample = '0;
        rd(8'h46, v2); check("R8 disabled counter holds", v2, v);

        // random rounds: R1 R2 R3 R4 R5 R6 R8
        for (int round = 0; round < 25; round++) begin
            for (int e = 0; e < NE; e++) begin
                v = ($urandom % 5 == 0) ? 32'd0 : ($urandom & $urandom);
                wr(8'(4 * e), v);
                wr(8'(4 * e + 1), $urandom);
            end
            for (int c = 0; c < NC; c++) begin
                r = $urandom % 5;
                v = (r == 0) ? 32'd0 : (r == 1) ? 32'd1 : (r == 2) ? 32'hFFFF_FFFE :
                    (r == 3) ? 32'hFFFF_FFFF : $urandom;
                wr(8'(8'h41 + 4 * c), v);
                cfg = {1'b1, 1'($urandom), 1'($urandom), 4'($urandom % 5)};
                wr(8'(8'h40 + 4 * c), {24'd0, 1'b1, cfg});
            end
            live = ($urandom % 3 == 0) ? ~(NL'(1) << ($urandom % NL)) : '1;
            for (int i = 0; i < 40; i++) begin
                sample = m_match[$urandom % NE] ^ ($urandom & $urandom & $urandom & $urandom);
                @(negedge clk);
            end
            for (int c = 0; c < NC; c++) wr(8'(8'h40 + 4 * c), {25'd0, 1'b0, m_cfg[c][5:0]});
            for (int c = 0; c < NC; c++) begin
                rd(8'(8'h42 + 4 * c), v); check("R2 R3 R4 R5 random count", v, m_cnt[c]);
                rd(8'(8'h43 + 4 * c), v); check("R6 random flag", v, {31'd0, m_flag[c]});
                wr(8'(8'h43 + 4 * c), 32'd1);
            end
            live = '1;
            sample = '0;
            idle(2);
        end

        summary();
    end
endmodule